// File: doc/BRIEF.md
# Edge-Triggered Interrupt Message Controller

This block collects a set of interrupt source lines, registers their current levels, and records each low-to-high transition as a pending event. It does not drive an interrupt wire toward the processor. Instead, every new edge on a source that is enabled becomes one posted memory write, a message. The message's target address and its payload both come from one of two programmable address registers. A per-source class bit selects which of the two is used.

Software reaches the block through a single-cycle register port. Through it, software programs the enable mask, the class selection and the two address registers. It also reads the live levels, the latched pending set and two filtered request views, one per class. The pending register clears on any access to it. Outgoing messages leave on a valid/ready write port, one beat per message. Enabled edges that have not yet been sent wait in a per-source outstanding set and are released lowest source first.

Top module: `elc_msg_irq`

## Requirements
- R1: After reset every register reads zero and `msg_valid` is low.
- R2: The level register (offset 0x028) returns the source lines sampled one clock earlier. It is read-only, so writes to it have no effect. Source positions outside `IMPL_MASK` (by default bit 9) always read 0 and never set a pending bit.
- R3: A source that goes from low to high sets its bit in the pending register (offset 0x01C). A source that stays high does not set the bit again, and a falling edge changes only the level bit.
- R4: A read of the pending register returns its contents and leaves it at zero. A write to it clears it, whatever the write data.
- R5: Request view 0 (offset 0x00C) reads level AND mask AND NOT class. Request view 1 (offset 0x014) reads level AND mask AND class. Both are read-only.
- R6: A rising edge on a source whose mask bit (offset 0x018) is clear produces no message. A rising edge on a source whose mask bit is set produces exactly one message.
- R7: A message's `msg_addr` is the selected address register with bits [4:0] cleared. Address register 1 (offset 0x010) is selected when the source's class bit (offset 0x024) is set, and address register 0 (offset 0x004) otherwise. The class bit and the register contents are taken in the cycle the message is loaded onto the port.
- R8: The message payload is the selected register's bits [4:0] as a 32-bit big-endian word, with the lowest-addressed byte on `msg_data[7:0]`. The five bits therefore appear on `msg_data[28:24]`, and every other bit is 0.
- R9: When several enabled sources rise in the same cycle, one message is sent for each of them, in ascending source-number order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R11: Read data appears on `reg_rdata` in the cycle after the read request. The address registers keep all 32 bits. Mask and class keep `NSRC` bits, and the bits above them read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source lines, active high |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| msg_valid | output | 1 | Message present on the write port |
| msg_ready | input | 1 | Write port accepts the message this cycle |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message payload in big-endian byte lanes |

## Verification
The bench builds the block with its defaults: eleven sources and an implemented mask of 0x5FF. With these values, bit 9 is the unimplemented position whose behaviour gets tested, and bit 10 is the highest live source for the view and class checks. With eleven sources, up to eleven messages can be outstanding at once. The bench raises four of them in one cycle while holding `msg_ready` low, which exercises the ascending release order and the hold behaviour on the port.

// File: rtl/elc_pkg.sv
package elc_pkg;

    localparam int REG_AW = 12;
    localparam int DW     = 32;

    localparam logic [REG_AW-1:0] OFF_ADDR0 = 12'h004;
    localparam logic [REG_AW-1:0] OFF_VIEW0 = 12'h00C;
    localparam logic [REG_AW-1:0] OFF_ADDR1 = 12'h010;
    localparam logic [REG_AW-1:0] OFF_VIEW1 = 12'h014;
    localparam logic [REG_AW-1:0] OFF_MASK  = 12'h018;
    localparam logic [REG_AW-1:0] OFF_PEND  = 12'h01C;
    localparam logic [REG_AW-1:0] OFF_CLASS = 12'h024;
    localparam logic [REG_AW-1:0] OFF_LEVEL = 12'h028;

    localparam int TAG_BITS = 5;

    // Value to big-endian byte lanes: byte at lowest address on [7:0].
    function automatic logic [DW-1:0] to_be_lanes(input logic [DW-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/elc_edge.sv
module elc_edge #(
    parameter int              NSRC      = 11,
    parameter logic [NSRC-1:0] IMPL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] level_o,
    output logic [NSRC-1:0] rise_o
);

    typedef struct packed {
        logic [NSRC-1:0] lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NSRC-1:0] live;

    always_comb begin
        live     = src_i & IMPL_MASK;
        st_d     = st_q;
        st_d.lvl = live;
        rise_o   = live & ~st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;

    // R3: a detected rise shows up as a high level on the next cycle
    a_r3_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((level_o & $past(rise_o)) == $past(rise_o)));

    // R2: unimplemented positions never read high
    a_r2_unimpl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o & ~IMPL_MASK) == '0);

endmodule

// File: rtl/elc_dispatch.sv
module elc_dispatch
    import elc_pkg::*;
#(
    parameter int NSRC = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] new_i,
    input  logic [NSRC-1:0] class_i,
    input  logic [DW-1:0]   addr0_i,
    input  logic [DW-1:0]   addr1_i,
    input  logic            msg_ready,
    output logic            msg_valid,
    output logic [DW-1:0]   msg_addr,
    output logic [DW-1:0]   msg_data
);

    typedef struct packed {
        logic [NSRC-1:0] outst;
        logic            valid;
        logic [DW-1:0]   addr;
        logic [DW-1:0]   data;
    } disp_st_t;

    disp_st_t st_d, st_q;
    logic [NSRC-1:0] pick;
    logic            port_free;
    logic            launch;
    logic [DW-1:0]   sel;

    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (st_q.outst[i]) pick = NSRC'(1) << i;
        end
        port_free = !st_q.valid || msg_ready;
        launch    = port_free && (|st_q.outst);
        sel       = (|(pick & class_i)) ? addr1_i : addr0_i;

        st_d = st_q;
        if (st_q.valid && msg_ready) st_d.valid = 1'b0;
        if (launch) begin
            st_d.valid = 1'b1;
            st_d.addr  = {sel[DW-1:TAG_BITS], {TAG_BITS{1'b0}}};
            st_d.data  = to_be_lanes({{(DW-TAG_BITS){1'b0}}, sel[TAG_BITS-1:0]});
            st_d.outst = st_q.outst & ~pick;
        end
        st_d.outst = st_d.outst | new_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_valid = st_q.valid;
    assign msg_addr  = st_q.addr;
    assign msg_data  = st_q.data;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    a_r7_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[TAG_BITS-1:0] == '0));

    a_r8_data_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_data & ~32'h1F00_0000) == '0));

    a_r9_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

endmodule

// File: rtl/elc_msg_irq.sv
module elc_msg_irq
    import elc_pkg::*;
#(
    parameter int              NSRC      = 11,
    parameter logic [NSRC-1:0] IMPL_MASK = 11'h5FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [DW-1:0]     msg_addr,
    output logic [DW-1:0]     msg_data
);

    localparam int PAD = DW - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] cls;
        logic [NSRC-1:0] pend;
        logic [DW-1:0]   addr0;
        logic [DW-1:0]   addr1;
        logic [DW-1:0]   rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [NSRC-1:0] level, rise;
    logic [DW-1:0]   rd_mux;
    logic            wr, pend_hit;

    elc_edge #(.NSRC(NSRC), .IMPL_MASK(IMPL_MASK)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .level_o (level),
        .rise_o  (rise)
    );

    always_comb begin
        wr       = reg_req && reg_we;
        pend_hit = reg_req && (reg_addr == OFF_PEND);

        unique case (reg_addr)
            OFF_ADDR0: rd_mux = st_q.addr0;
            OFF_ADDR1: rd_mux = st_q.addr1;
            OFF_VIEW0: rd_mux = {{PAD{1'b0}}, level & st_q.mask & ~st_q.cls};
            OFF_VIEW1: rd_mux = {{PAD{1'b0}}, level & st_q.mask & st_q.cls};
            OFF_MASK:  rd_mux = {{PAD{1'b0}}, st_q.mask};
            OFF_CLASS: rd_mux = {{PAD{1'b0}}, st_q.cls};
            OFF_PEND:  rd_mux = {{PAD{1'b0}}, st_q.pend};
            OFF_LEVEL: rd_mux = {{PAD{1'b0}}, level};
            default:   rd_mux = '0;
        endcase

        st_d = st_q;
        if (reg_req && !reg_we) st_d.rdata = rd_mux;
        if (wr) begin
            unique case (reg_addr)
                OFF_ADDR0: st_d.addr0 = reg_wdata;
                OFF_ADDR1: st_d.addr1 = reg_wdata;
                OFF_MASK:  st_d.mask  = reg_wdata[NSRC-1:0];
                OFF_CLASS: st_d.cls   = reg_wdata[NSRC-1:0];
                default: ;
            endcase
        end
        // any access empties the pending set; a fresh edge still lands
        st_d.pend = (pend_hit ? '0 : st_q.pend) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    elc_dispatch #(.NSRC(NSRC)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_i     (rise & st_q.mask),
        .class_i   (st_q.cls),
        .addr0_i   (st_q.addr0),
        .addr1_i   (st_q.addr1),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((st_q.pend & $past(rise)) == $past(rise)));

    a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_addr == OFF_PEND && rise == '0) |=> (st_q.pend == '0));

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0 && !msg_valid && !u_disp.st_q.valid && u_disp.st_q.outst == '0)
            |=> !msg_valid);

endmodule

// File: tb/tb_elc_msg_irq.sv
module tb_elc_msg_irq;
    import elc_pkg::*;

    localparam int NSRC = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic ready = 1'b1;
    logic mvalid;
    logic [31:0] maddr, mdata;

    int n_chk = 0, n_err = 0;
    int log_n = 0;
    logic [31:0] log_a [32];
    logic [31:0] log_d [32];

    always #2 clk = ~clk;

    elc_msg_irq dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .reg_req(req), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .msg_ready(ready), .msg_valid(mvalid),
        .msg_addr(maddr), .msg_data(mdata)
    );

    // transfer happens at the next posedge when both are high at negedge
    always @(negedge clk) begin
        if (rst_n && mvalid && ready && log_n < 32) begin
            log_a[log_n] = maddr;
            log_d[log_n] = mdata;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        req = 1'b0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {mask, class, src, level, view0, view1}
    localparam logic [65:0] VEC [4] = '{
        {11'h7FF, 11'h000, 11'h00F, 11'h00F, 11'h00F, 11'h000},
        {11'h0F0, 11'h0C0, 11'h0FF, 11'h0FF, 11'h030, 11'h0C0},
        {11'h5FF, 11'h400, 11'h7FF, 11'h5FF, 11'h1FF, 11'h400},
        {11'h000, 11'h7FF, 11'h7FF, 11'h5FF, 11'h000, 11'h000}
    };

    initial begin
        #(4 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        cyc(3);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 msg_valid", {31'b0, mvalid}, 32'h0);
        rd(OFF_ADDR0, v); chk("R1 addr0", v, 0);
        rd(OFF_ADDR1, v); chk("R1 addr1", v, 0);
        rd(OFF_MASK, v);  chk("R1 mask", v, 0);
        rd(OFF_CLASS, v); chk("R1 class", v, 0);
        rd(OFF_PEND, v);  chk("R1 pend", v, 0);
        rd(OFF_LEVEL, v); chk("R1 level", v, 0);

        // R11 readback widths and unmapped offsets
        wr(OFF_ADDR0, 32'h1234_5678);
        rd(OFF_ADDR0, v); chk("R11 addr0 readback", v, 32'h1234_5678);
        wr(OFF_MASK, 32'hFFFF_FFFF);
        rd(OFF_MASK, v); chk("R11 mask width", v, 32'h0000_07FF);
        rd(12'h030, v); chk("R11 unmapped", v, 0);

        // R2 level is read-only
        wr(OFF_LEVEL, 32'h7FF);
        rd(OFF_LEVEL, v); chk("R2 level write ignored", v, 0);

        // R5 table of view patterns
        for (int k = 0; k < 4; k++) begin
            src = '0;
            cyc(3);
            wr(OFF_MASK, {21'b0, VEC[k][65:55]});
            wr(OFF_CLASS, {21'b0, VEC[k][54:44]});
            src = VEC[k][43:33];
            cyc(3);
            rd(OFF_LEVEL, v); chk("R2 level table", v, {21'b0, VEC[k][32:22]});
            rd(OFF_VIEW0, v); chk("R5 view0 table", v, {21'b0, VEC[k][21:11]});
            rd(OFF_VIEW1, v); chk("R5 view1 table", v, {21'b0, VEC[k][10:0]});
        end
        wr(OFF_VIEW0, 32'h0); wr(OFF_VIEW1, 32'h0);
        rd(OFF_VIEW1, v); chk("R5 view write ignored", v, 0);

        // R3 / R4 pending behaviour
        src = '0; wr(OFF_MASK, 0); cyc(3);
        wr(OFF_PEND, 0);
        src = 11'h001; cyc(3);
        rd(OFF_PEND, v); chk("R3 rise sets pend", v, 32'h1);
        rd(OFF_PEND, v); chk("R4 read clears; R3 held high no reset", v, 0);
        src = '0; cyc(3);
        rd(OFF_PEND, v); chk("R3 fall no pend", v, 0);
        rd(OFF_LEVEL, v); chk("R3 fall clears level", v, 0);
        src = 11'h001; cyc(3);
        wr(OFF_PEND, 32'h5);
        rd(OFF_PEND, v); chk("R4 write clears", v, 0);
        src = 11'h200; cyc(3);
        rd(OFF_PEND, v); chk("R2 bit9 no pend", v, 0);
        rd(OFF_LEVEL, v); chk("R2 bit9 level", v, 0);

        // R6 masked edge is silent
        src = '0; cyc(3);
        base = log_n;
        src = 11'h004; cyc(8);
        chk("R6 masked no message", log_n - base, 0);

        // R6/R7/R8 class 0
        src = '0; cyc(3);
        wr(OFF_MASK, 32'h004); wr(OFF_CLASS, 0); wr(OFF_ADDR0, 32'hABCD_EF37);
        base = log_n;
        src = 11'h004; cyc(8);
        chk("R6 one message", log_n - base, 1);
        chk("R7 addr class0", log_a[base], 32'hABCD_EF20);
        chk("R8 data class0", log_d[base], 32'h1700_0000);

        // R7/R8 class 1
        src = '0; cyc(3);
        wr(OFF_MASK, 32'h008); wr(OFF_CLASS, 32'h008); wr(OFF_ADDR1, 32'h0000_1045);
        base = log_n;
        src = 11'h008; cyc(8);
        chk("R6 one message class1", log_n - base, 1);
        chk("R7 addr class1", log_a[base], 32'h0000_1040);
        chk("R8 data class1", log_d[base], 32'h0500_0000);

        // R9 / R10 burst with back-pressure
        src = '0; cyc(3);
        wr(OFF_MASK, 32'h00F); wr(OFF_CLASS, 32'h00A);
        wr(OFF_ADDR0, 32'h0000_0100); wr(OFF_ADDR1, 32'h0000_0201);
        ready = 1'b0;
        base = log_n;
        src = 11'h00F; cyc(5);
        chk("R10 valid held", {31'b0, mvalid}, 32'h1);
        chk("R10 first addr", maddr, 32'h0000_0100);
        cyc(4);
        chk("R10 still valid", {31'b0, mvalid}, 32'h1);
        chk("R10 addr stable", maddr, 32'h0000_0100);
        chk("R10 data stable", mdata, 32'h0);
        ready = 1'b1;
        cyc(12);
        chk("R9 count", log_n - base, 4);
        chk("R9 order0 addr", log_a[base],     32'h0000_0100);
        chk("R9 order1 addr", log_a[base + 1], 32'h0000_0200);
        chk("R9 order1 data", log_d[base + 1], 32'h0100_0000);
        chk("R9 order2 addr", log_a[base + 2], 32'h0000_0100);
        chk("R9 order3 addr", log_a[base + 3], 32'h0000_0200);
        chk("R9 drained", {31'b0, mvalid}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule